// File: doc/BRIEF.md
# Serial EEPROM Slave Write Controller

This block is the two-wire (I2C) slave front end of a small serial EEPROM. Its storage is a 256-byte register array, and the chip's read path reaches that array through a combinational read port. A bus master opens a transfer with a Start condition and sends a device byte. That byte holds a fixed 4-bit type code, three bits that must equal the address-select pins, and a direction bit. The master then sends a word address and up to sixteen data bytes. The slave acknowledges each accepted byte and collects the data in a page buffer. It writes the array only when a Stop arrives at a byte boundary.

A committed write starts a busy period of a fixed number of system clocks. During that period the slave ignores the bus entirely, so it does not acknowledge even its own device byte. A write-protect pin, sampled at Stop, blocks every change to the array. A protected transfer is still acknowledged but skips both the update and the busy period. SCL and SDA are sampled by an oversampling system clock. Start and Stop are found as SDA edges while SCL is high.

Top module: `seeprom_wr_ctrl`

## Requirements
- R1: After reset, `sda_pull_o` and `busy_o` are low and every array location reads 0xFF.
- R2: The slave pulls SDA low during the ninth SCL clock of the device byte only when bits [7:4] equal 4'b1010, bits [3:1] equal `addr_sel_i` and bit 0 (direction) is 0. Otherwise it never pulls SDA for any byte until the next Start.
- R3: After an accepted device byte, the word-address byte and every data byte are acknowledged in their ninth clock. The word-address byte loads the write pointer.
- R4: Each data byte goes to the pointer location, and then the pointer's low 4 bits increment modulo 16 with the upper 4 bits unchanged. A later byte to the same location replaces an earlier one.
- R5: The array keeps its contents until a Stop that follows a complete data byte. That Stop writes all buffered bytes in the same clock.
- R6: A committed write raises `busy_o` for exactly `WR_CYCLES` system clocks.
- R7: While `busy_o` is high, no byte is acknowledged (the device byte included), and bus activity starts no transfer and changes no array location.
- R8: With `wp_i` high at Stop, the array is unchanged and `busy_o` stays low, while the data bytes are still acknowledged.
- R9: A Stop or a repeated Start inside a byte discards the buffered data without a write. A repeated Start begins a new device byte.
- R10: `rd_data_o` shows the array byte at `rd_addr_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock oversampling the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| wp_i | input | 1 | Write protect for the whole array |
| addr_sel_i | input | 3 | Device address select pins |
| busy_o | output | 1 | Internal write cycle in progress |
| rd_addr_i | input | 8 | Array read address |
| rd_data_o | output | 8 | Array read data |

## Verification
The properties assume that SCL and SDA hold each level for several system clocks, so that the synchronizer sees every edge. They also assume that SDA changes while SCL is high only to form a Start or a Stop, and that `wp_i` and `addr_sel_i` stay steady around a Stop. The bench drives every bus level for six clocks, with data set only while SCL is low. It changes the protect and select pins only between transfers. Random transfers vary the device match, protection, word address and length from none to eighteen bytes, so that page wrap-around and overwrite are covered.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [3:0]  DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WADDR,
    PH_DATA,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/seeprom_line_sync.sv
module seeprom_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // SDA edges while SCL held high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/seeprom_rx_fsm.sv
module seeprom_rx_fsm
  import seeprom_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic [2:0] addr_sel_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  output logic       ack_o,
  output logic [7:0] byte_o,
  output logic       wa_vld_o,
  output logic       dat_vld_o,
  output logic       clr_o,
  output logic       stop_ok_o
);
  phase_e     phase_q;
  logic [3:0] cnt_q;
  logic       in_ack_q;
  logic [7:0] sh_q;
  logic       dev_match;

  assign dev_match = (sh_q[7:4] == DEV_TYPE) && (sh_q[3:1] == addr_sel_i) && !sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      in_ack_q  <= 1'b0;
      sh_q      <= '0;
      ack_o     <= 1'b0;
      byte_o    <= '0;
      wa_vld_o  <= 1'b0;
      dat_vld_o <= 1'b0;
      clr_o     <= 1'b0;
      stop_ok_o <= 1'b0;
    end else begin
      wa_vld_o  <= 1'b0;
      dat_vld_o <= 1'b0;
      clr_o     <= 1'b0;
      stop_ok_o <= 1'b0;
      if (busy_i) begin
        phase_q  <= PH_IDLE;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        ack_o    <= 1'b0;
      end else if (start_i) begin
        phase_q  <= PH_DEV;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        ack_o    <= 1'b0;
        clr_o    <= 1'b1;
      end else if (stop_i) begin
        // a legal Stop follows exactly one SCL rise after the ack clock
        if (phase_q == PH_DATA && !in_ack_q && cnt_q <= 4'd1) stop_ok_o <= 1'b1;
        else clr_o <= 1'b1;
        phase_q  <= PH_IDLE;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        ack_o    <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
        if (scl_rise_i && !in_ack_q && cnt_q != 4'd8) begin
          sh_q  <= {sh_q[6:0], sda_i};
          cnt_q <= cnt_q + 4'd1;
        end else if (scl_fall_i && !in_ack_q && cnt_q == 4'd8) begin
          in_ack_q <= 1'b1;
          byte_o   <= sh_q;
          case (phase_q)
            PH_DEV: begin
              if (dev_match) begin
                ack_o   <= 1'b1;
                phase_q <= PH_WADDR;
              end else begin
                phase_q <= PH_SKIP;
              end
            end
            PH_WADDR: begin
              ack_o    <= 1'b1;
              wa_vld_o <= 1'b1;
              phase_q  <= PH_DATA;
            end
            PH_DATA: begin
              ack_o     <= 1'b1;
              dat_vld_o <= 1'b1;
            end
            default: ack_o <= 1'b0;
          endcase
        end else if (scl_fall_i && in_ack_q) begin
          in_ack_q <= 1'b0;
          ack_o    <= 1'b0;
          cnt_q    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/seeprom_page_array.sv
module seeprom_page_array
  import seeprom_pkg::*;
#(
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wa_vld_i,
  input  logic              dat_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o,
  output logic              commit_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned PAGE  = 1 << PAGE_W;

  logic [7:0]             mem_q  [DEPTH];
  logic [7:0]             pbuf_q [PAGE];
  logic [PAGE-1:0]        mask_q;
  logic [ADDR_W-1:0]      ptr_q;
  logic [ADDR_W-PAGE_W-1:0] page_base;
  logic [PAGE_W-1:0]      slot;

  assign page_base = ptr_q[ADDR_W-1:PAGE_W];
  assign slot      = ptr_q[PAGE_W-1:0];
  assign commit_o  = stop_i & ~wp_i & (|mask_q);
  assign rdata_o   = mem_q[raddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      mask_q <= '0;
      for (int i = 0; i < PAGE; i++) pbuf_q[i] <= '0;
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= 8'hFF;
    end else begin
      if (commit_o) begin
        for (int i = 0; i < PAGE; i++) begin
          if (mask_q[i]) mem_q[{page_base, PAGE_W'(i)}] <= pbuf_q[i];
        end
      end
      if (clr_i || stop_i) begin
        mask_q <= '0;
      end else if (wa_vld_i) begin
        ptr_q  <= byte_i;
        mask_q <= '0;
      end else if (dat_vld_i) begin
        pbuf_q[slot]         <= byte_i;
        mask_q[slot]         <= 1'b1;
        ptr_q[PAGE_W-1:0]    <= slot + 1'b1; // wraps inside the page
      end
    end
  end
endmodule

// File: rtl/seeprom_wr_ctrl.sv
module seeprom_wr_ctrl
  import seeprom_pkg::*;
#(
  parameter int unsigned WR_CYCLES   = 150000,
  parameter int unsigned PAGE_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic       wp_i,
  input  logic [2:0] addr_sel_i,
  output logic       busy_o,
  input  logic [7:0] rd_addr_i,
  output logic [7:0] rd_data_o
);
  localparam int unsigned CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;

  logic sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic [7:0] rx_byte;
  logic wa_vld, dat_vld, clr, stop_ok, commit;
  logic busy_q;
  logic [CNT_W-1:0] wcnt_q;

  seeprom_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_p),
    .stop_o     (stop_p)
  );

  seeprom_rx_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy_q),
    .addr_sel_i (addr_sel_i),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_p),
    .stop_i     (stop_p),
    .ack_o      (sda_pull_o),
    .byte_o     (rx_byte),
    .wa_vld_o   (wa_vld),
    .dat_vld_o  (dat_vld),
    .clr_o      (clr),
    .stop_ok_o  (stop_ok)
  );

  seeprom_page_array #(.PAGE_W(PAGE_W)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .wa_vld_i  (wa_vld),
    .dat_vld_i (dat_vld),
    .byte_i    (rx_byte),
    .stop_i    (stop_ok),
    .wp_i      (wp_i),
    .raddr_i   (rd_addr_i),
    .rdata_o   (rd_data_o),
    .commit_o  (commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wcnt_q <= '0;
    end else if (commit) begin
      busy_q <= 1'b1;
      wcnt_q <= '0;
    end else if (busy_q) begin
      if (wcnt_q == CNT_W'(WR_CYCLES - 1)) busy_q <= 1'b0;
      else wcnt_q <= wcnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/seeprom_wr_ctrl_chk.sv
module seeprom_wr_ctrl_chk #(
  parameter int unsigned WR_CYCLES = 150000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wp_i,
  input logic       sda_pull_o,
  input logic       busy_o,
  input logic [7:0] rd_addr_i,
  input logic [7:0] rd_data_o
);
  int unsigned busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_run <= 0;
    else busy_run <= busy_o ? busy_run + 1 : 0;
  end

  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_run < WR_CYCLES));

  p_busy_mute_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_pull_o);

  p_wp_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(wp_i));

  p_mem_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$rose(busy_o) && $stable(rd_addr_i)) |-> $stable(rd_data_o));
endmodule

bind seeprom_wr_ctrl seeprom_wr_ctrl_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wp_i       (wp_i),
  .sda_pull_o (sda_pull_o),
  .busy_o     (busy_o),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o)
);

// File: tb/seeprom_wr_ctrl_bench.sv
`timescale 1ns/1ps
module seeprom_wr_ctrl_bench;
  localparam int WR = 1000;
  localparam int Q  = 6;

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda_m = 1, wp = 0;
  logic [2:0] asel = 3'b101;
  logic [7:0] rd_addr = 0;
  logic sda_pull, busy;
  logic [7:0] rd_data;
  wire  sda_bus = sda_m & ~sda_pull;

  int n_tests = 0, n_fail = 0;
  int run = 0, last_run = 0, cycles = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] wbuf [32];

  always #10 clk = ~clk;

  seeprom_wr_ctrl #(.WR_CYCLES(WR)) u_seeprom_wr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .wp_i(wp), .addr_sel_i(asel), .busy_o(busy),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always @(negedge clk) begin
    cycles++;
    if (busy) run++;
    else begin
      if (run != 0) last_run = run;
      run = 0;
    end
    if (cycles > 190000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1; tick(Q); scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q); scl = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl = 1; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1; tick(Q); scl = 1; tick(Q / 2);
    ack = sda_pull;
    tick(Q - Q / 2); scl = 0; tick(Q);
  endtask

  function automatic logic [7:0] dev_byte(input logic [2:0] sel);
    return {4'b1010, sel, 1'b0};
  endfunction

  task automatic xfer(input logic [7:0] dev, input logic [7:0] wa, input int n,
                      output logic dev_ack, output int acks);
    logic a;
    acks = 0;
    bus_start();
    send_byte(dev, dev_ack);
    send_byte(wa, a); acks += int'(a);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); acks += int'(a);
    end
    bus_stop();
  endtask

  task automatic model_write(input logic [7:0] wa, input int n);
    for (int k = 0; k < n; k++) begin
      logic [3:0] lo;
      lo = wa[3:0] + 4'(k);
      ref_mem[{wa[7:4], lo}] = wbuf[k];
    end
  endtask

  task automatic wait_idle();
    while (busy) tick(1);
    tick(2);
  endtask

  task automatic check_image(input string req);
    int errs, fa;
    errs = 0; fa = 0;
    for (int a = 0; a < 256; a++) begin
      rd_addr = 8'(a); #1;
      if (rd_data !== ref_mem[a]) begin
        if (errs == 0) fa = a;
        errs++;
      end
    end
    rd_addr = 8'(fa); #1;
    chk(errs == 0, req, $sformatf("array image @%0h", fa), int'(rd_data), int'(ref_mem[fa]));
  endtask

  initial begin
    logic a, da;
    int acks;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
    tick(3); rst_n = 1; tick(3);

    // R1 / R10: reset state
    chk(sda_pull == 0, "R1", "sda_pull after reset", sda_pull, 0);
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    check_image("R1 R10");

    // R2 R3 R5 R6: directed byte write
    bus_start();
    send_byte(dev_byte(3'b101), a);
    chk(a == 1, "R2", "device byte ack", a, 1);
    send_byte(8'h42, a);
    chk(a == 1, "R3", "word address ack", a, 1);
    send_byte(8'h5A, a);
    chk(a == 1, "R3", "data ack", a, 1);
    rd_addr = 8'h42; #1;
    chk(rd_data == 8'hFF, "R5", "array before Stop", rd_data, 8'hFF);
    bus_stop();
    chk(busy == 1, "R6", "busy after Stop", busy, 1);
    ref_mem[8'h42] = 8'h5A;

    // R7: own address ignored while busy
    wbuf[0] = 8'h77;
    xfer(dev_byte(3'b101), 8'h43, 1, da, acks);
    chk(da == 0, "R7", "device ack while busy", da, 0);
    chk(acks == 0, "R7", "byte acks while busy", acks, 0);
    wait_idle();
    chk(last_run == WR, "R6", "busy length", last_run, WR);
    check_image("R5 R7");

    // R2: type mismatch, pin mismatch, read direction
    for (int k = 0; k < 3; k++) wbuf[k] = 8'(k + 1);
    xfer({4'b1011, 3'b101, 1'b0}, 8'h10, 3, da, acks);
    chk(da == 0 && acks == 0, "R2", "type mismatch acks", acks + int'(da), 0);
    xfer(dev_byte(3'b100), 8'h10, 3, da, acks);
    chk(da == 0 && acks == 0, "R2", "pin mismatch acks", acks + int'(da), 0);
    xfer({4'b1010, 3'b101, 1'b1}, 8'h10, 3, da, acks);
    chk(da == 0 && acks == 0, "R2", "read direction acks", acks + int'(da), 0);
    tick(2);
    chk(busy == 0, "R2", "busy after ignored transfers", busy, 0);
    check_image("R2");

    // R4: page wrap and overwrite
    for (int k = 0; k < 6; k++) wbuf[k] = 8'hA0 + 8'(k);
    xfer(dev_byte(3'b101), 8'h3C, 6, da, acks);
    chk(acks == 7, "R3", "page acks", acks, 7);
    model_write(8'h3C, 6);
    wait_idle();
    check_image("R4 wrap");
    for (int k = 0; k < 18; k++) wbuf[k] = 8'hC0 + 8'(k);
    xfer(dev_byte(3'b101), 8'h50, 18, da, acks);
    model_write(8'h50, 18);
    wait_idle();
    check_image("R4 overwrite");

    // R8: write protect
    wp = 1;
    for (int k = 0; k < 3; k++) wbuf[k] = 8'h11;
    xfer(dev_byte(3'b101), 8'h60, 3, da, acks);
    chk(da == 1 && acks == 4, "R8", "acks under protect", acks, 4);
    tick(2);
    chk(busy == 0, "R8", "busy under protect", busy, 0);
    wp = 0;
    check_image("R8");

    // R9: Stop inside a byte
    bus_start();
    send_byte(dev_byte(3'b101), a);
    send_byte(8'h80, a);
    send_byte(8'h11, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    tick(2);
    chk(busy == 0, "R9", "busy after mid-byte Stop", busy, 0);
    check_image("R9 stop");

    // R9: repeated Start inside a byte
    bus_start();
    send_byte(dev_byte(3'b101), a);
    send_byte(8'h90, a);
    send_byte(8'h22, a);
    put_bit(1'b1); put_bit(1'b0);
    bus_start();
    send_byte(dev_byte(3'b101), a);
    chk(a == 1, "R9", "ack after repeated Start", a, 1);
    send_byte(8'hA0, a);
    send_byte(8'h33, a);
    bus_stop();
    ref_mem[8'hA0] = 8'h33;
    wait_idle();
    check_image("R9 restart");

    // random transfers
    for (int it = 0; it < 16; it++) begin
      logic match, wpr, exp_busy;
      logic [7:0] wa, dev;
      int n;
      asel  = 3'($urandom_range(0, 7));
      match = ($urandom_range(0, 4) != 0);
      wpr   = ($urandom_range(0, 4) == 0);
      n     = $urandom_range(0, 18);
      wa    = 8'($urandom);
      dev   = match ? dev_byte(asel) : dev_byte(asel ^ 3'b010);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wp = wpr;
      xfer(dev, wa, n, da, acks);
      chk(da == match, "R2", "random device ack", da, match);
      chk(acks == (match ? n + 1 : 0), "R3", "random byte acks", acks, match ? n + 1 : 0);
      exp_busy = match && !wpr && n > 0;
      chk(busy == exp_busy, "R8", "random busy", busy, exp_busy);
      wp = 0;
      if (exp_busy) begin
        model_write(wa, n);
        wait_idle();
      end
    end
    check_image("R4 random");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule